// File: doc/BRIEF.md
# Serial Sync Word Detector

The detector sits behind a bit-clock recovery stage and watches the recovered NRZ bit stream. A qualifying strobe marks each new bit. Every accepted bit is shifted into a 32-bit history. On that same strobe the newest bits are compared against a programmed pattern of one to four bytes. When the number of differing bits is within a programmed limit, the block emits a single-cycle pulse. Matching never stops after the first hit: every position at which the window agrees with the pattern yields its own pulse, overlapping windows included.

The pattern is given as four byte inputs. The size code chooses how many of them take part, starting from the first byte. The oldest bit of the window is compared with the most significant bit of the first byte. The newest bit is compared with the least significant bit of the last byte in use. A downstream packet handler can take the pulse as the point where payload begins.

Top module: `sync_word_detector`

## Requirements
- R1: After an active-low reset, `match_o` is 0.
- R2: `size_i` codes 0, 1, 2 and 3 select a window of 8, 16, 24 and 32 bits. A stream that reproduces the active pattern exactly gives a pulse for each code.
- R3: The oldest bit of the window is compared with bit 7 of `pat_b0_i`. The newest bit is compared with bit 0 of the last active byte. Byte order is b0, then b1, b2, b3. A stream with the two bytes swapped does not match.
- R4: A match is declared when the count of differing bits is at most `tol_i` (0 to 3). One more differing bit than `tol_i` gives no pulse.
- R5: Pattern bytes beyond the selected size have no effect on the result.
- R6: No pulse is produced until at least as many accepted bits as the window length have arrived since reset or since enable was last raised. A window made of the cleared history does not match, even when the pattern is all zeros.
- R7: A match pulse is high for exactly one clock, in the cycle after the strobe that completes the window. `match_o` is 0 in every cycle that does not follow an accepted strobe.
- R8: Matching is continuous. With pattern 0xFF at size 0 and tolerance 0, a run of 12 one-bits gives 5 pulses, on bits 8 through 12.
- R9: While `en_i` is 0, strobes are ignored and the history and bit count are cleared, so a window split by an enable drop does not match.
- R10: `bit_i` is ignored in cycles where `bit_vld_i` is 0.
- R11: A change to size, tolerance or pattern bytes is applied to the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Detection enable; low clears history |
| bit_i | input | 1 | Recovered data bit |
| bit_vld_i | input | 1 | Strobe marking a new bit on `bit_i` |
| size_i | input | 2 | Pattern length code: 8*(code+1) bits |
| tol_i | input | 2 | Number of bit errors allowed (0..3) |
| pat_b0_i | input | 8 | First pattern byte, compared with the oldest bits |
| pat_b1_i | input | 8 | Second pattern byte |
| pat_b2_i | input | 8 | Third pattern byte |
| pat_b3_i | input | 8 | Fourth pattern byte |
| match_o | output | 1 | One-cycle match pulse |

## Verification
Two functions can fall in the same cycle: evaluating the window at a completing strobe, and applying a new setting. The first case moves the tolerance from 0 to 1 between the seventh and eighth bits of a pattern with one flipped bit. The eighth strobe is then judged by the new tolerance, so a pulse must appear. The second case drops enable after seven bits of a pattern and sends the eighth bit after enable returns. It is judged by the absence of a pulse, which shows that the clearing won over the partly filled window.

// File: rtl/syncdet_pkg.sv
// Package: shared constants and types for the serial sync word detector.
// Assumes the pattern is built from whole bytes and holds at most four of them.
package syncdet_pkg;
    localparam int SD_BYTE_W = 8;
    localparam int SD_BYTES  = 4;
    localparam int SD_HIST_W = SD_BYTE_W * SD_BYTES;
    localparam int SD_CNT_W  = $clog2(SD_HIST_W + 1);

    typedef logic [SD_BYTE_W-1:0] sd_byte_t;
    typedef logic [SD_HIST_W-1:0] sd_word_t;
    typedef logic [SD_CNT_W-1:0]  sd_cnt_t;
endpackage

// File: rtl/sd_history.sv
// Module: bit history shift register with a saturating fill counter.
// Assumes accept_i is the enabled strobe. While clr_i is high, the history and
// count are forced to zero. The next-state values are brought out so the
// compare logic can judge the bit that is arriving in the same cycle.
module sd_history #(
    parameter int HIST_W = 32,
    parameter int CNT_W  = $clog2(HIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              accept_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_next_o,
    output logic [CNT_W-1:0]  fill_next_o
);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(HIST_W);

    logic [HIST_W-1:0] hist_q;
    logic [CNT_W-1:0]  fill_q;

    // Next history: the new bit enters at position 0 and older bits move up.
    always_comb begin
        if (clr_i)
            hist_next_o = '0;
        else if (accept_i)
            hist_next_o = {hist_q[HIST_W-2:0], bit_i};
        else
            hist_next_o = hist_q;
    end

    // Next fill count: counts accepted bits and holds at the history width.
    always_comb begin
        if (clr_i)
            fill_next_o = '0;
        else if (accept_i && (fill_q != FILL_MAX))
            fill_next_o = fill_q + 1'b1;
        else
            fill_next_o = fill_q;
    end

    // State registers for the history and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= hist_next_o;
            fill_q <= fill_next_o;
        end
    end
endmodule

// File: rtl/sd_pattern.sv
// Module: aligns the programmed bytes with the history and builds the bit mask.
// Assumes byte 0 holds the oldest bits. The last active byte lines up with
// history bit 0, the newest bit. Bytes beyond the size code are masked out.
module sd_pattern #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    parameter int SIZE_W = $clog2(NBYTES),
    parameter int CNT_W  = $clog2(NBYTES * BYTE_W + 1)
) (
    input  logic [SIZE_W-1:0]        size_i,
    input  logic [NBYTES*BYTE_W-1:0] bytes_i,
    output logic [NBYTES*BYTE_W-1:0] pat_o,
    output logic [NBYTES*BYTE_W-1:0] mask_o,
    output logic [CNT_W-1:0]         need_o
);
    localparam int W = NBYTES * BYTE_W;

    logic [W-1:0] full_pat;
    int           unused_bytes;

    // Concatenate the bytes so that byte 0 takes the most significant slot.
    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        assign full_pat[W-1-k*BYTE_W -: BYTE_W] = bytes_i[k*BYTE_W +: BYTE_W];
    end

    // Count of byte slots that sit past the last active byte.
    always_comb unused_bytes = NBYTES - 1 - int'(size_i);

    // Shift the pattern down so that the last active byte lands at bit 0.
    always_comb begin
        pat_o  = full_pat >> (unused_bytes * BYTE_W);
        mask_o = {W{1'b1}} >> (unused_bytes * BYTE_W);
    end

    // Window length in bits, used by the fill-count gate.
    always_comb need_o = CNT_W'((int'(size_i) + 1) * BYTE_W);
endmodule

// File: rtl/sd_popcount.sv
// Module: counts the set bits of a vector with a pairwise adder tree.
// Assumes W is a power of two. The tree is purely combinational.
module sd_popcount #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int LEVELS = $clog2(W);

    logic [CNT_W-1:0] node [LEVELS+1][W];

    // Leaf level: each input bit becomes a one-bit count.
    for (genvar i = 0; i < W; i++) begin : g_leaf
        assign node[0][i] = CNT_W'(vec_i[i]);
    end

    // Each level adds adjacent pairs of partial sums; unused slots are zero.
    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        for (genvar j = 0; j < W; j++) begin : g_node
            if (j < (W >> l)) begin : g_sum
                assign node[l][j] = node[l-1][2*j] + node[l-1][2*j+1];
            end else begin : g_zero
                assign node[l][j] = '0;
            end
        end
    end

    assign cnt_o = node[LEVELS][0];
endmodule

// File: rtl/sync_word_detector.sv
// Module: top of the serial sync word detector.
// Compares the recent history with a pattern of 1 to 4 bytes, allowing up to
// tol_i bit errors. When the strobe that completes a matching window arrives,
// the block raises a one-cycle registered pulse in the following cycle.
// Assumes bit_vld_i is high for one cycle per recovered bit and all inputs are
// synchronous to clk.
module sync_word_detector
    import syncdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       bit_i,
    input  logic       bit_vld_i,
    input  logic [1:0] size_i,
    input  logic [1:0] tol_i,
    input  logic [7:0] pat_b0_i,
    input  logic [7:0] pat_b1_i,
    input  logic [7:0] pat_b2_i,
    input  logic [7:0] pat_b3_i,
    output logic       match_o
);
    logic     accept;
    sd_word_t hist_next;
    sd_cnt_t  fill_next;
    sd_word_t pat_aligned;
    sd_word_t pat_mask;
    sd_cnt_t  need_bits;
    sd_word_t diff;
    sd_cnt_t  err_cnt;
    logic     hit;
    logic     match_q;

    // Only enabled strobes move the history.
    always_comb accept = en_i & bit_vld_i;

    sd_history #(
        .HIST_W (SD_HIST_W),
        .CNT_W  (SD_CNT_W)
    ) u_history (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!en_i),
        .accept_i    (accept),
        .bit_i       (bit_i),
        .hist_next_o (hist_next),
        .fill_next_o (fill_next)
    );

    sd_pattern #(
        .NBYTES (SD_BYTES),
        .BYTE_W (SD_BYTE_W),
        .SIZE_W (2),
        .CNT_W  (SD_CNT_W)
    ) u_pattern (
        .size_i  (size_i),
        .bytes_i ({pat_b3_i, pat_b2_i, pat_b1_i, pat_b0_i}),
        .pat_o   (pat_aligned),
        .mask_o  (pat_mask),
        .need_o  (need_bits)
    );

    // Positions in the active window where history and pattern disagree.
    always_comb diff = (hist_next ^ pat_aligned) & pat_mask;

    sd_popcount #(
        .W     (SD_HIST_W),
        .CNT_W (SD_CNT_W)
    ) u_popcount (
        .vec_i (diff),
        .cnt_o (err_cnt)
    );

    // A hit needs a strobe, a full window and an error count within limit.
    always_comb hit = accept && (fill_next >= need_bits)
                      && (err_cnt <= SD_CNT_W'(tol_i));

    // Register the hit so the pulse lasts one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else
            match_q <= hit;
    end

    assign match_o = match_q;
endmodule

// File: rtl/sd_checker.sv
// Module: assertion checker for sync_word_detector, attached by bind.
// Keeps its own count of accepted bits so that the fill rule is checked
// without reading the design's counter.
module sd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       bit_vld_i,
    input logic [1:0] size_i,
    input logic [1:0] tol_i,
    input logic [5:0] err_cnt,
    input logic       match_o
);
    int seen;

    // Independent count of enabled strobes, saturating at 32.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)
            seen <= 0;
        else if (bit_vld_i && seen < 32)
            seen <= seen + 1;
    end

    // R7: a pulse only follows an enabled strobe.
    assert_pulse_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(en_i && bit_vld_i));

    // R9: a disabled cycle never leads to a pulse.
    assert_idle_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !match_o);

    // R6: a pulse requires at least a full window of accepted bits.
    assert_window_filled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (seen >= 8 * (int'($past(size_i)) + 1)));

    // R4: the judged error count was within the tolerance in force.
    assert_errors_within_tol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(err_cnt) <= {4'b0, $past(tol_i)}));

    // R1: the output is low while reset is applied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            assert_reset_low_R1: assert (!match_o || $past(rst_n));
    end
endmodule

bind sync_word_detector sd_checker u_sd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .bit_vld_i (bit_vld_i),
    .size_i    (size_i),
    .tol_i     (tol_i),
    .err_cnt   (err_cnt),
    .match_o   (match_o)
);

// File: tb/test_sync_word_detector.sv
// Directed bench for sync_word_detector: one task per scenario.
module test_sync_word_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic [1:0] size_i = 2'd0;
    logic [1:0] tol_i = 2'd0;
    logic [7:0] pat_b0_i = 8'h00;
    logic [7:0] pat_b1_i = 8'h00;
    logic [7:0] pat_b2_i = 8'h00;
    logic [7:0] pat_b3_i = 8'h00;
    logic       match_o;

    int checks = 0;
    int fails  = 0;
    logic got;
    int   pulses;
    logic last_m;

    sync_word_detector i_sync_word_detector (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .bit_i(bit_i),
        .bit_vld_i(bit_vld_i), .size_i(size_i), .tol_i(tol_i),
        .pat_b0_i(pat_b0_i), .pat_b1_i(pat_b1_i), .pat_b2_i(pat_b2_i),
        .pat_b3_i(pat_b3_i), .match_o(match_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One strobe, then one idle cycle with bit_i inverted (R10); got = pulse.
    task automatic push(input logic b);
        @(negedge clk);
        bit_i = b; bit_vld_i = 1'b1;
        @(negedge clk);
        bit_vld_i = 1'b0; bit_i = ~b;
        got = match_o;
    endtask

    // Sends the low n bits of v, oldest first; counts pulses, records the last.
    task automatic send(input logic [31:0] v, input int n);
        pulses = 0;
        for (int i = n - 1; i >= 0; i--) begin
            push(v[i]);
            if (got) pulses++;
        end
        last_m = got;
    endtask

    task automatic restart();
        @(negedge clk); en_i = 1'b0;
        @(negedge clk); en_i = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 reset output", int'(match_o), 0);
    endtask

    task automatic t_fill();
        size_i = 0; tol_i = 0; pat_b0_i = 8'h00; restart();
        send(32'h0, 7);
        check("R6 no pulse before full window", pulses, 0);
        push(1'b0);
        check("R6 pulse at eighth bit", int'(got), 1);
    endtask

    task automatic t_sizes();
        size_i = 0; tol_i = 0; pat_b0_i = 8'hA5; pat_b1_i = 8'h3C;
        pat_b2_i = 8'h99; pat_b3_i = 8'h66; restart();
        send(32'hA5, 8);
        check("R2 R10 size0 single pulse", pulses, 1);
        check("R5 size0 pulse on last bit", int'(last_m), 1);
        @(negedge clk);
        check("R7 pulse lasts one cycle", int'(match_o), 0);
        size_i = 2; pat_b0_i = 8'hC3; pat_b1_i = 8'h5A; pat_b2_i = 8'h96;
        pat_b3_i = 8'h77; restart();
        send(32'hC35A96, 24);
        check("R2 size2 pulse", pulses, 1);
        check("R5 size2 last bit", int'(last_m), 1);
        size_i = 3; pat_b0_i = 8'hDE; pat_b1_i = 8'hAD; pat_b2_i = 8'hBE;
        pat_b3_i = 8'hEF; restart();
        send(32'hDEADBEEF, 32);
        check("R2 size3 pulse", pulses, 1);
    endtask

    task automatic t_order();
        size_i = 1; tol_i = 0; pat_b0_i = 8'h12; pat_b1_i = 8'h34; restart();
        send(32'h1234, 16);
        check("R3 in-order pattern", int'(last_m), 1);
        restart();
        send(32'h3412, 16);
        check("R3 swapped bytes rejected", pulses, 0);
    endtask

    task automatic t_tol();
        size_i = 1; pat_b0_i = 8'hF0; pat_b1_i = 8'h0F;
        tol_i = 2; restart(); send(32'hF00C, 16);
        check("R4 two errors tol2", int'(last_m), 1);
        restart(); send(32'hF008, 16);
        check("R4 three errors tol2", pulses, 0);
        tol_i = 3; restart(); send(32'hF008, 16);
        check("R4 three errors tol3", int'(last_m), 1);
        tol_i = 0; restart(); send(32'hF00E, 16);
        check("R4 one error tol0", pulses, 0);
    endtask

    task automatic t_continuous();
        size_i = 0; tol_i = 0; pat_b0_i = 8'hFF; restart();
        send(32'hFFF, 12);
        check("R8 repeated pulses", pulses, 5);
    endtask

    task automatic t_enable();
        size_i = 0; tol_i = 0; pat_b0_i = 8'hA5; restart();
        send(32'h52, 7);
        restart();
        push(1'b1);
        check("R9 split window rejected", int'(got), 0);
        @(negedge clk); en_i = 1'b0;
        send(32'hA5, 8);
        check("R9 strobes ignored while disabled", pulses, 0);
        en_i = 1'b1;
    endtask

    task automatic t_reconfig();
        size_i = 0; tol_i = 0; pat_b0_i = 8'hA5; restart();
        send(32'h52, 7);
        tol_i = 1;
        push(1'b0);
        check("R11 new tolerance on next strobe", int'(got), 1);
        tol_i = 0;
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fill();
        t_sizes();
        t_order();
        t_tol();
        t_continuous();
        t_enable();
        t_reconfig();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule